// File: doc/BRIEF.md
# Dual-Bank DRAM Address Multiplexer

This block drives the multiplexed address pins of two DRAM banks. One bank holds the even words and the other holds the odd words. Each output bit picks one of three sources: the latched CPU row field, the latched CPU column field, or that bank's own refresh row counter. The even bank and the odd bank have separate selects, so they can be driven at the same time from different sources. When the CPU uses one bank, the other bank takes a row-only refresh in the same bus cycle. When no access is waiting, a refresh request refreshes both banks together.

A four-state sequencer runs each cycle. Its states are `ST_IDLE` (waiting), `ST_ROW` (row phase), `ST_COL` (column phase) and `ST_DONE` (recovery). Every cycle follows the same path: IDLE→ROW on an accepted request, ROW→COL always, COL→DONE always, and DONE→IDLE always. The address path is built from identical 3-bit slices. Each bank has its own refresh counter, and that counter advances only when its bank is refreshed. As a result, a hidden refresh never makes the accessed bank skip a row.

Top module: `dram_amux_top`

## Requirements
- R1: After reset the sequencer is idle. Both strobe pairs and `cpu_ack` are low. Both refresh counters are zero, so `ma_even` and `ma_odd` read 0.
- R2: `cpu_addr[0]` picks the accessed bank: 0 is the even bank (strobe bit 0) and 1 is the odd bank (strobe bit 1). Both `row_strobe` bits are high in ROW and COL and low otherwise. `col_strobe` is high only for the accessed bank, and only in COL.
- R3: In ROW of an access, the accessed bank's address equals the row field `cpu_addr[2*MA_W:MA_W+1]` latched at acceptance.
- R4: In COL of an access, the accessed bank's address equals the column field `cpu_addr[MA_W:1]` latched at acceptance.
- R5: During ROW and COL of an access, the other bank's address equals its own refresh counter, and that bank never sees a column strobe.
- R6: At the COL→DONE transition, the counter of each refreshed bank advances by one. The accessed bank's counter is unchanged.
- R7: A refresh counter wraps from 2^MA_W−1 to 0.
- R8: A `ref_req` seen in IDLE with no `cpu_req` starts a refresh-only cycle. Both banks show their counters, neither gets a column strobe, and both counters advance.
- R9: If `cpu_req` and `ref_req` are both high in IDLE, the CPU access wins.
- R10: `cpu_ack` is high for exactly the DONE cycle of an access. Requests and `cpu_addr` are sampled only in IDLE, so changes in later states have no effect.
- R11: In IDLE and DONE, each bank's address equals its refresh counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU access request, sampled in IDLE |
| cpu_addr | input | 2*MA_W+1 | Word address: bit 0 bank, then column, then row |
| ref_req | input | 1 | Refresh request, sampled in IDLE |
| ma_even | output | MA_W | Even-bank multiplexed address |
| ma_odd | output | MA_W | Odd-bank multiplexed address |
| row_strobe | output | 2 | Row strobe per bank (bit 0 even) |
| col_strobe | output | 2 | Column strobe per bank (bit 0 even) |
| cpu_ack | output | 1 | Access completion pulse |

## Verification
Accesses alternate between the even and odd banks with row and column fields that are all zeros, all ones, and mixed patterns. This separates a correct row/column swap from a wrong bank decode or a shared select. Refresh-only cycles, and cycles where both requests arrive together, show whether refresh and access are merged the right way and whether CPU priority holds. The address is changed in the middle of a cycle and `cpu_req` is held across back-to-back cycles, to show that requests are sampled only in IDLE. A long run of refreshes after reset shows the counter wrap.

// File: rtl/dram_amux_pkg.sv
package dram_amux_pkg;
    typedef enum logic [1:0] {
        SRC_ROW = 2'd0,
        SRC_COL = 2'd1,
        SRC_REF = 2'd2
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ROW  = 2'd1,
        ST_COL  = 2'd2,
        ST_DONE = 2'd3
    } state_e;
endpackage

// File: rtl/dram_amux_slice.sv
module dram_amux_slice
    import dram_amux_pkg::*;
#(
    parameter int W = 3
) (
    input  logic [W-1:0] row_in,
    input  logic [W-1:0] col_in,
    input  logic [W-1:0] ref_even,
    input  logic [W-1:0] ref_odd,
    input  src_e         sel_even,
    input  src_e         sel_odd,
    output logic [W-1:0] out_even,
    output logic [W-1:0] out_odd
);
    function automatic logic pick3(src_e s, logic a, logic b, logic c);
        logic r;
        unique case (s)
            SRC_ROW: r = a;
            SRC_COL: r = b;
            default: r = c;
        endcase
        return r;
    endfunction

    for (genvar ch = 0; ch < W; ch++) begin : g_chan
        always_comb begin
            out_even[ch] = pick3(sel_even, row_in[ch], col_in[ch], ref_even[ch]);
            out_odd[ch]  = pick3(sel_odd,  row_in[ch], col_in[ch], ref_odd[ch]);
        end
    end
endmodule

// File: rtl/dram_amux_refcnt.sv
module dram_amux_refcnt #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count <= '0;
        else if (inc) count <= count + 1'b1;
    end

    assert_step_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> count == $past(count) + 1'b1);
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(count));
endmodule

// File: rtl/dram_amux_seq.sv
module dram_amux_seq
    import dram_amux_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_req,
    input  logic       cpu_bank,
    input  logic       ref_req,
    output state_e     state,
    output logic       acc_q,
    output logic       bank_q,
    output logic       accept,
    output src_e       sel_even,
    output src_e       sel_odd,
    output logic [1:0] row_strobe,
    output logic [1:0] col_strobe,
    output logic [1:0] ref_inc,
    output logic       cpu_ack
);
    state_e state_nx;
    logic   start;

    assign accept = (state == ST_IDLE) && cpu_req;
    assign start  = (state == ST_IDLE) && (cpu_req || ref_req);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_ROW;
            ST_ROW:  state_nx = ST_COL;
            ST_COL:  state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            acc_q  <= 1'b0;
            bank_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (start) begin
                acc_q  <= cpu_req;
                bank_q <= cpu_req ? cpu_bank : 1'b0;
            end
        end
    end

    always_comb begin
        sel_even   = SRC_REF;
        sel_odd    = SRC_REF;
        row_strobe = 2'b00;
        col_strobe = 2'b00;
        ref_inc    = 2'b00;
        cpu_ack    = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_ROW: begin
                row_strobe = 2'b11;
                if (acc_q) begin
                    if (bank_q) sel_odd  = SRC_ROW;
                    else        sel_even = SRC_ROW;
                end
            end
            ST_COL: begin
                row_strobe = 2'b11;
                if (acc_q) begin
                    if (bank_q) begin
                        sel_odd    = SRC_COL;
                        col_strobe = 2'b10;
                        ref_inc    = 2'b01;
                    end else begin
                        sel_even   = SRC_COL;
                        col_strobe = 2'b01;
                        ref_inc    = 2'b10;
                    end
                end else begin
                    ref_inc = 2'b11;
                end
            end
            ST_DONE: cpu_ack = acc_q;
        endcase
    end

    assert_col_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(col_strobe));
    assert_col_in_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (col_strobe & ~row_strobe) == 2'b00);
    assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);
    assert_cpu_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cpu_req) |=> (state == ST_ROW && acc_q));
endmodule

// File: rtl/dram_amux_top.sv
module dram_amux_top
    import dram_amux_pkg::*;
#(
    parameter int MA_W    = 9,
    parameter int SLICE_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_req,
    input  logic [2*MA_W:0]     cpu_addr,
    input  logic                ref_req,
    output logic [MA_W-1:0]     ma_even,
    output logic [MA_W-1:0]     ma_odd,
    output logic [1:0]          row_strobe,
    output logic [1:0]          col_strobe,
    output logic                cpu_ack
);
    localparam int AW      = 2 * MA_W + 1;
    localparam int N_SLICE = MA_W / SLICE_W;

    state_e                state;
    logic                  acc_q, bank_q, accept;
    src_e                  sel_even, sel_odd;
    logic [1:0]            ref_inc;
    logic [AW-1:0]         addr_q;
    logic [1:0][MA_W-1:0]  cnt;
    logic [MA_W-1:0]       row_f, col_f;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      addr_q <= '0;
        else if (accept) addr_q <= cpu_addr;
    end

    assign col_f = addr_q[MA_W:1];
    assign row_f = addr_q[2*MA_W:MA_W+1];

    dram_amux_seq u_seq (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_bank(cpu_addr[0]),
        .ref_req(ref_req), .state(state), .acc_q(acc_q), .bank_q(bank_q),
        .accept(accept), .sel_even(sel_even), .sel_odd(sel_odd),
        .row_strobe(row_strobe), .col_strobe(col_strobe), .ref_inc(ref_inc),
        .cpu_ack(cpu_ack)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        dram_amux_refcnt #(.W(MA_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .inc(ref_inc[b]), .count(cnt[b])
        );
    end

    for (genvar s = 0; s < N_SLICE; s++) begin : g_slice
        dram_amux_slice #(.W(SLICE_W)) u_slice (
            .row_in  (row_f[s*SLICE_W +: SLICE_W]),
            .col_in  (col_f[s*SLICE_W +: SLICE_W]),
            .ref_even(cnt[0][s*SLICE_W +: SLICE_W]),
            .ref_odd (cnt[1][s*SLICE_W +: SLICE_W]),
            .sel_even(sel_even),
            .sel_odd (sel_odd),
            .out_even(ma_even[s*SLICE_W +: SLICE_W]),
            .out_odd (ma_odd[s*SLICE_W +: SLICE_W])
        );
    end

    assert_row_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ROW && acc_q && !bank_q) |-> ma_even == row_f);
    assert_row_odd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ROW && acc_q && bank_q) |-> ma_odd == row_f);
    assert_hidden_ref_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COL && acc_q && !bank_q) |-> ma_odd == cnt[1]);
    assert_idle_ref_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (ma_even == cnt[0] && ma_odd == cnt[1]));
endmodule

// File: tb/dram_amux_top_tb.sv
`timescale 1ns/1ps
module dram_amux_top_tb;
    localparam int MA_W = 9;
    localparam int AW   = 2 * MA_W + 1;
    localparam int MOD  = 1 << MA_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cpu_req = 1'b0;
    logic [AW-1:0]   cpu_addr = '0;
    logic            ref_req = 1'b0;
    logic [MA_W-1:0] ma_even, ma_odd;
    logic [1:0]      row_strobe, col_strobe;
    logic            cpu_ack;

    int checks = 0, failures = 0, cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dram_amux_top #(.MA_W(MA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .ref_req(ref_req), .ma_even(ma_even), .ma_odd(ma_odd),
        .row_strobe(row_strobe), .col_strobe(col_strobe), .cpu_ack(cpu_ack)
    );

    // behavioural reference: 0 idle, 1 row, 2 col, 3 recovery
    int mst, macc, mbank, mrow, mcol;
    int mcnt[2];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mst = 0; macc = 0; mbank = 0; mrow = 0; mcol = 0;
            mcnt[0] = 0; mcnt[1] = 0;
        end else begin
            case (mst)
                0: if (cpu_req) begin
                       macc = 1; mbank = cpu_addr[0];
                       mcol = cpu_addr[MA_W:1]; mrow = cpu_addr[2*MA_W:MA_W+1];
                       mst = 1;
                   end else if (ref_req) begin
                       macc = 0; mst = 1;
                   end
                1: mst = 2;
                2: begin
                       if (macc) mcnt[1-mbank] = (mcnt[1-mbank] + 1) % MOD;
                       else begin
                           mcnt[0] = (mcnt[0] + 1) % MOD;
                           mcnt[1] = (mcnt[1] + 1) % MOD;
                       end
                       mst = 3;
                   end
                default: mst = 0;
            endcase
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_ma(int b, output string tag);
        if ((mst == 1 || mst == 2) && macc && mbank == b) begin
            tag = (mst == 1) ? "R3 row address" : "R4 column address";
            return (mst == 1) ? mrow : mcol;
        end
        if ((mst == 1 || mst == 2) && macc) tag = "R5 hidden refresh address";
        else if (mst == 1 || mst == 2)      tag = "R8 refresh-only address";
        else                                tag = "R11 idle address";
        return mcnt[b];
    endfunction

    // per-cycle comparison against the reference, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            string t0, t1;
            int e0, e1;
            e0 = exp_ma(0, t0);
            e1 = exp_ma(1, t1);
            chk({t0, " even"}, ma_even, e0);
            chk({t1, " odd"},  ma_odd,  e1);
            chk("R2 row strobes", row_strobe, (mst == 1 || mst == 2) ? 3 : 0);
            chk("R2 column strobes", col_strobe, (mst == 2 && macc) ? (1 << mbank) : 0);
            chk("R10 ack", cpu_ack, (mst == 3 && macc) ? 1 : 0);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [AW-1:0] mk(int row, int col, int bank);
        return {row[MA_W-1:0], col[MA_W-1:0], bank[0]};
    endfunction

    // one operation; scrambles the address after acceptance (R10)
    task automatic op(bit cr, bit rr, logic [AW-1:0] a);
        @(posedge clk); #1;
        cpu_req = cr; ref_req = rr; cpu_addr = a;
        @(posedge clk); #1;
        cpu_req = 0; ref_req = 0; cpu_addr = ~a;
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 0; cpu_req = 0; ref_req = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        chk("R1 reset ma_even", ma_even, 0);
        chk("R1 reset ma_odd", ma_odd, 0);
        chk("R1 reset strobes", {row_strobe, col_strobe}, 0);
        chk("R1 reset ack", cpu_ack, 0);

        op(1, 0, mk(9'h1A5, 9'h05A, 0));
        @(negedge clk);
        chk("R6 accessed even counter unchanged", ma_even, 0);
        chk("R6 refreshed odd counter advanced", ma_odd, 1);

        op(1, 0, mk(9'h000, 9'h1FF, 1));
        op(1, 0, mk(9'h1FF, 9'h000, 0));
        op(1, 0, mk(9'h0F3, 9'h10C, 1));
        op(0, 1, '0);
        @(negedge clk);
        chk("R8 both advance even", ma_even, 3);
        chk("R8 both advance odd", ma_odd, 3);

        // R9: both requests together; access must win
        @(posedge clk); #1;
        cpu_req = 1; ref_req = 1; cpu_addr = mk(9'h155, 9'h0AA, 1);
        @(posedge clk); #1;
        cpu_req = 0; ref_req = 0;
        @(posedge clk); #1;
        @(negedge clk);
        chk("R9 column strobe for access", col_strobe, 2);
        chk("R9 access column address", ma_odd, 9'h0AA);
        repeat (2) @(posedge clk);
        #1;

        // R10: request held high across back-to-back cycles
        cpu_req = 1; cpu_addr = mk(9'h077, 9'h188, 0);
        repeat (10) @(posedge clk);
        #1 cpu_req = 0;
        repeat (6) @(posedge clk);
        #1;

        // R7: wrap of both counters
        do_reset();
        for (int i = 0; i < MOD - 1; i++) op(0, 1, '0);
        @(negedge clk);
        chk("R7 counter at maximum", ma_even, MOD - 1);
        op(0, 1, '0);
        @(negedge clk);
        chk("R7 counter wrapped even", ma_even, 0);
        chk("R7 counter wrapped odd", ma_odd, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule